// File: doc/BRIEF.md
# Bus-Cycle-Aware Reset Sequencer

This block turns an external active-low reset pin into an orderly internal reset. The pin passes through a two-stage synchronizer, so nothing happens until the system clock has captured it. A stopped clock therefore produces no reset at all. An ordinary request is deferred while a bus cycle is open, so a write already under way completes. A request flagged as catastrophic is taken on the next clock edge, whatever the bus is doing.

While internal reset is active, every port direction register is forced to zero, which makes every pin an input. Every pin-function enable is also cleared, which leaves the pins as general-purpose ports. Register writes are refused during this time. After the synchronized pin rises, internal reset is stretched for a fixed number of clocks. The mode-select pins are captured on the final clock of that stretch. A single-cycle start pulse then tells the processor to fetch its reset vector.

The configuration write strobes are plain, single-cycle enables. They have no back-pressure: outside reset a write is always taken on the clock edge where its enable is high.

Top module: `rst_ctl_top`

## Requirements
- R1: From an idle bus (bus_active low), a low level on rst_pin_n driven just after one rising edge brings sys_rst_n low after the third following rising edge. Before that, sys_rst_n stays high.
- R2: Out of the first clock edges with the pin held low, sys_rst_n is low, port_dir reads all zeros and pin_fn reads all zeros.
- R3: A non-catastrophic request that finds bus_active high and bus_end low is held pending. sys_rst_n stays high until the edge on which bus_end (or bus_active low) is sampled. It falls on that same edge.
- R4: When catastrophic is high while a request is recognized, sys_rst_n falls on the next edge, even with bus_active high and bus_end low.
- R5: After the synchronized pin rises, sys_rst_n stays low for exactly HOLD_CYC further clocks: it rises at the (3+HOLD_CYC)-th edge after the pin rises. A pin that goes low again during this stretch returns the block to reset, and the count starts over from the next release.
- R6: cpu_start is high for exactly one cycle: the first cycle in which sys_rst_n is high again.
- R7: Port direction register p occupies port_dir[p*8+7:p*8]. One clock after sys_rst_n goes low, all of port_dir and pin_fn read zero. Writes presented while sys_rst_n is low have no effect.
- R8: A direction write presented in the same cycle that the awaited bus_end arrives is stored, and is visible while sys_rst_n first reads low. It is cleared one clock later.
- R9: mode_cfg takes the value of mode_pins from the last clock of the reset stretch. It holds that value while sys_rst_n stays high, even if mode_pins change.
- R10: Outside reset, a write is visible one clock after it is presented. dir_wr_en bit p loads dir_wr_data into port p, and fn_wr_en loads fn_wr_data into pin_fn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| catastrophic | input | 1 | Marks a pending reset as catastrophic (no bus wait) |
| bus_active | input | 1 | A bus cycle is open |
| bus_end | input | 1 | The open bus cycle finishes in this clock |
| mode_pins | input | 3 | Mode-select pin levels, captured at release |
| dir_wr_en | input | 4 | Per-port direction register write enable |
| dir_wr_data | input | 8 | Direction write data (1 = output) |
| fn_wr_en | input | 1 | Pin-function enable write |
| fn_wr_data | input | 6 | Pin-function enable write data |
| sys_rst_n | output | 1 | Internal reset, active low |
| cpu_start | output | 1 | One-cycle reset-vector fetch pulse |
| port_dir | output | 32 | All port direction registers, port 0 in the low byte |
| pin_fn | output | 6 | Pin-function enables |
| mode_cfg | output | 3 | Latched operating configuration |

## Verification
The closing edge of a deferred bus cycle can carry a configuration write. The block must let that write land and enter reset on the very same edge. The bench provokes this case: it raises bus_end and a direction write strobe together while a request is pending. It then expects the written byte and a low sys_rst_n in the following cycle, and an all-zero port one cycle after that. A second collision is a catastrophic request during an open bus cycle, where the bench requires reset on the next edge. A pin that returns low during the release stretch is also checked: the bench expects reset to reach the processor at the later, restarted release time.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_WAIT    = 3'd1,
    ST_HOLD    = 3'd2,
    ST_STRETCH = 3'd3,
    ST_START   = 3'd4
  } rst_st_e;
endpackage

// File: rtl/rst_ctl_sync.sv
module rst_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_in,
  output logic q_out
);
  // Power-up content reads as "pin low", so the chip starts in reset.
  logic [STAGES-1:0] chain = '0;

  always_ff @(posedge clk) begin
    chain[0] <= d_in;
    for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/rst_ctl_seq.sv
module rst_ctl_seq
  import rst_ctl_pkg::*;
#(
  parameter int HOLD_CYC = 16,
  parameter int MODE_W   = 3
) (
  input  logic              clk,
  input  logic              pin_low,
  input  logic              cat_req,
  input  logic              bus_active,
  input  logic              bus_end,
  input  logic [MODE_W-1:0] mode_pins,
  output logic              sys_rst_n,
  output logic              cpu_start,
  output logic [MODE_W-1:0] mode_cfg
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  rst_st_e            st = ST_HOLD;
  rst_st_e            st_nx;
  logic [CW-1:0]      cnt = '0;
  logic [MODE_W-1:0]  mode_q = '0;
  logic               take_now;

  // Reset may enter when catastrophic, or when no bus write is in flight.
  assign take_now = cat_req || !bus_active || bus_end;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_RUN, ST_START: begin
        if (pin_low)       st_nx = take_now ? ST_HOLD : ST_WAIT;
        else               st_nx = ST_RUN;
      end
      ST_WAIT:             if (take_now) st_nx = ST_HOLD;
      ST_HOLD:             if (!pin_low) st_nx = ST_STRETCH;
      ST_STRETCH: begin
        if (pin_low)           st_nx = ST_HOLD;
        else if (cnt == LAST)  st_nx = ST_START;
      end
      default:             st_nx = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    st  <= st_nx;
    cnt <= (st == ST_STRETCH && st_nx == ST_STRETCH) ? cnt + 1'b1 : '0;
    if (st == ST_STRETCH && st_nx == ST_START) mode_q <= mode_pins;
  end

  assign sys_rst_n = !(st == ST_HOLD || st == ST_STRETCH);
  assign cpu_start = (st == ST_START);
  assign mode_cfg  = mode_q;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R3: a pending request with the bus still busy leaves reset released
  a_r3_defer_bus: assert property (@(posedge clk) disable iff (!armed)
    (st == ST_WAIT && !cat_req && bus_active && !bus_end) |=> sys_rst_n);

  // R4: catastrophic request enters reset on the next edge
  a_r4_cat_now: assert property (@(posedge clk) disable iff (!armed)
    ((st == ST_RUN || st == ST_WAIT || st == ST_START) && pin_low && cat_req)
      |=> !sys_rst_n);

  // R5: stretch counter never passes its limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!armed)
    cnt <= LAST);

  // R6: start pulse marks release and lasts one cycle
  a_r6_start_on_release: assert property (@(posedge clk) disable iff (!armed)
    $rose(sys_rst_n) |-> cpu_start);
  a_r6_start_single: assert property (@(posedge clk) disable iff (!armed)
    cpu_start |=> !cpu_start);

  // R9: configuration frozen while out of reset
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!armed)
    (sys_rst_n && $past(sys_rst_n)) |-> $stable(mode_cfg));
endmodule

// File: rtl/rst_ctl_portcfg.sv
module rst_ctl_portcfg #(
  parameter int NPORT = 4,
  parameter int PW    = 8,
  parameter int NFN   = 6
) (
  input  logic                clk,
  input  logic                in_rst,
  input  logic [NPORT-1:0]    dir_wr_en,
  input  logic [PW-1:0]       dir_wr_data,
  input  logic                fn_wr_en,
  input  logic [NFN-1:0]      fn_wr_data,
  output logic [NPORT*PW-1:0] port_dir,
  output logic [NFN-1:0]      pin_fn
);
  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [PW-1:0] dir_q = '0;
      always_ff @(posedge clk) begin
        if (in_rst)            dir_q <= '0;
        else if (dir_wr_en[p]) dir_q <= dir_wr_data;
      end
      assign port_dir[p*PW +: PW] = dir_q;
    end
  endgenerate

  logic [NFN-1:0] fn_q = '0;
  always_ff @(posedge clk) begin
    if (in_rst)        fn_q <= '0;
    else if (fn_wr_en) fn_q <= fn_wr_data;
  end
  assign pin_fn = fn_q;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R7: one clock into reset, all ports are inputs and functions are off
  a_r7_defaults: assert property (@(posedge clk) disable iff (!armed)
    in_rst |=> (port_dir == '0 && pin_fn == '0));

  // R10: function write lands one clock later outside reset
  a_r10_fn_write: assert property (@(posedge clk) disable iff (!armed)
    (!in_rst && fn_wr_en) |=> (pin_fn == $past(fn_wr_data)));
endmodule

// File: rtl/rst_ctl_top.sv
module rst_ctl_top #(
  parameter int HOLD_CYC    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 3,
  parameter int NPORT       = 4,
  parameter int PW          = 8,
  parameter int NFN         = 6
) (
  input  logic                clk,
  input  logic                rst_pin_n,
  input  logic                catastrophic,
  input  logic                bus_active,
  input  logic                bus_end,
  input  logic [MODE_W-1:0]   mode_pins,
  input  logic [NPORT-1:0]    dir_wr_en,
  input  logic [PW-1:0]       dir_wr_data,
  input  logic                fn_wr_en,
  input  logic [NFN-1:0]      fn_wr_data,
  output logic                sys_rst_n,
  output logic                cpu_start,
  output logic [NPORT*PW-1:0] port_dir,
  output logic [NFN-1:0]      pin_fn,
  output logic [MODE_W-1:0]   mode_cfg
);
  logic pin_sync;
  logic rst_n_int;

  rst_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .d_in  (rst_pin_n),
    .q_out (pin_sync)
  );

  rst_ctl_seq #(.HOLD_CYC(HOLD_CYC), .MODE_W(MODE_W)) u_seq (
    .clk        (clk),
    .pin_low    (!pin_sync),
    .cat_req    (catastrophic),
    .bus_active (bus_active),
    .bus_end    (bus_end),
    .mode_pins  (mode_pins),
    .sys_rst_n  (rst_n_int),
    .cpu_start  (cpu_start),
    .mode_cfg   (mode_cfg)
  );

  rst_ctl_portcfg #(.NPORT(NPORT), .PW(PW), .NFN(NFN)) u_cfg (
    .clk         (clk),
    .in_rst      (!rst_n_int),
    .dir_wr_en   (dir_wr_en),
    .dir_wr_data (dir_wr_data),
    .fn_wr_en    (fn_wr_en),
    .fn_wr_data  (fn_wr_data),
    .port_dir    (port_dir),
    .pin_fn      (pin_fn)
  );

  assign sys_rst_n = rst_n_int;
endmodule

// File: tb/rst_ctl_top_tb_top.sv
`timescale 1ns/1ps
module rst_ctl_top_tb_top;
  localparam int H = 16;

  logic        clk = 1'b0;
  logic        rst_pin_n = 1'b0;
  logic        catastrophic = 1'b0;
  logic        bus_active = 1'b0;
  logic        bus_end = 1'b0;
  logic [2:0]  mode_pins = 3'b101;
  logic [3:0]  dir_wr_en = '0;
  logic [7:0]  dir_wr_data = '0;
  logic        fn_wr_en = 1'b0;
  logic [5:0]  fn_wr_data = '0;
  logic        sys_rst_n;
  logic        cpu_start;
  logic [31:0] port_dir;
  logic [5:0]  pin_fn;
  logic [2:0]  mode_cfg;

  rst_ctl_top #(.HOLD_CYC(H)) dut_i (
    .clk(clk), .rst_pin_n(rst_pin_n), .catastrophic(catastrophic),
    .bus_active(bus_active), .bus_end(bus_end), .mode_pins(mode_pins),
    .dir_wr_en(dir_wr_en), .dir_wr_data(dir_wr_data),
    .fn_wr_en(fn_wr_en), .fn_wr_data(fn_wr_data),
    .sys_rst_n(sys_rst_n), .cpu_start(cpu_start), .port_dir(port_dir),
    .pin_fn(pin_fn), .mode_cfg(mode_cfg)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  function automatic logic [31:0] obs(int sel);
    case (sel)
      0: obs = {31'd0, sys_rst_n};
      1: obs = {31'd0, cpu_start};
      2: obs = port_dir;
      3: obs = {26'd0, pin_fn};
      default: obs = {29'd0, mode_cfg};
    endcase
  endfunction

  // driver side: schedule an expectation d cycles ahead (d >= 1)
  task automatic expect_in(int d, int sel, logic [31:0] val, string tag);
    exp_t e;
    e.due = cyc + d; e.sel = sel; e.val = val; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        logic [31:0] act;
        act = obs(sbq[i].sel);
        checks++;
        if (act !== sbq[i].val) begin
          fails++;
          $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h",
                   sbq[i].tag, sbq[i].sel, cyc, act, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic finish_up();
    foreach (sbq[i]) begin
      checks++; fails++;
      $display("FAIL %s never sampled actual=none expected=%h", sbq[i].tag, sbq[i].val);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic release_pin(logic [2:0] mode, string tag);
    mode_pins = mode;
    rst_pin_n = 1'b1;
    expect_in(H + 2, 0, 32'd0, {tag, " R5 still in reset"});
    expect_in(H + 2, 1, 32'd0, {tag, " R6 no early start"});
    expect_in(H + 3, 0, 32'd1, {tag, " R5 released"});
    expect_in(H + 3, 1, 32'd1, {tag, " R6 start pulse"});
    expect_in(H + 3, 4, {29'd0, mode}, {tag, " R9 mode latched"});
    expect_in(H + 4, 1, 32'd0, {tag, " R6 pulse ends"});
    step(H + 4);
  endtask

  initial begin
    step(5);
    // R2: power-up state with pin held low
    expect_in(1, 0, 32'd0, "R2 sys_rst_n low");
    expect_in(1, 2, 32'd0, "R2 port_dir zero");
    expect_in(1, 3, 32'd0, "R2 pin_fn zero");
    step(2);
    release_pin(3'b101, "first");

    // R9: mode pins change after release, latched value holds
    mode_pins = 3'b010;
    expect_in(3, 4, 32'd5, "R9 mode held");
    step(3);

    // R10: run-mode writes
    dir_wr_en = 4'b0100; dir_wr_data = 8'hA5;
    fn_wr_en = 1'b1; fn_wr_data = 6'h2B;
    expect_in(1, 2, 32'h00A5_0000, "R10 port 2 dir");
    expect_in(1, 3, 32'h0000_002B, "R10 pin_fn");
    step(1);
    dir_wr_en = 4'b0001; dir_wr_data = 8'h3C; fn_wr_en = 1'b0;
    expect_in(1, 2, 32'h00A5_003C, "R10 port 0 dir");
    step(1);
    dir_wr_en = '0;

    // R3/R8: deferred reset, write landing on the closing edge
    bus_active = 1'b1; bus_end = 1'b0;
    rst_pin_n = 1'b0;
    expect_in(3, 0, 32'd1, "R3 deferred at edge 3");
    expect_in(5, 0, 32'd1, "R3 deferred at edge 5");
    step(5);
    bus_end = 1'b1; dir_wr_en = 4'b0001; dir_wr_data = 8'h77;
    expect_in(1, 0, 32'd0, "R3 reset on bus_end");
    expect_in(1, 2, 32'h00A5_0077, "R8 closing write stored");
    expect_in(2, 2, 32'd0, "R7 ports cleared");
    expect_in(2, 3, 32'd0, "R7 functions cleared");
    step(1);
    bus_end = 1'b0; bus_active = 1'b0; dir_wr_en = '0;
    step(2);
    release_pin(3'b011, "second");

    // R4: catastrophic during an open bus cycle
    fn_wr_en = 1'b1; fn_wr_data = 6'h15;
    step(1);
    fn_wr_en = 1'b0;
    bus_active = 1'b1; bus_end = 1'b0; catastrophic = 1'b1;
    rst_pin_n = 1'b0;
    expect_in(2, 0, 32'd1, "R4 not before sync");
    expect_in(3, 0, 32'd0, "R4 immediate reset");
    expect_in(4, 3, 32'd0, "R7 functions cleared");
    step(5);
    // R7: writes during reset are ignored
    dir_wr_en = 4'hF; dir_wr_data = 8'hFF; fn_wr_en = 1'b1; fn_wr_data = 6'h3F;
    expect_in(1, 2, 32'd0, "R7 dir write ignored");
    expect_in(1, 3, 32'd0, "R7 fn write ignored");
    step(1);
    dir_wr_en = '0; fn_wr_en = 1'b0;
    catastrophic = 1'b0; bus_active = 1'b0;
    step(1);
    release_pin(3'b110, "third");

    // R1: idle-bus reset timing
    rst_pin_n = 1'b0;
    expect_in(2, 0, 32'd1, "R1 high at edge 2");
    expect_in(3, 0, 32'd0, "R1 low at edge 3");
    step(5);
    // R5: pin returns low during the stretch
    rst_pin_n = 1'b1;
    expect_in(H + 3, 0, 32'd0, "R5 restart keeps reset");
    step(5);
    rst_pin_n = 1'b0;
    step(5);
    release_pin(3'b001, "restart");

    step(4);
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
    end
  end
endmodule